// File: doc/BRIEF.md
# Chipset Interrupt Message Generator

This block converts internal hot-plug and power-management events into outbound interrupt messages. Hot-plug status bits, one per event source such as a presence-detect change or an attention button, are set by sideband management writes or by in-band hot-plug messages. When message-signalled interrupts are enabled, a pending hot-plug status produces one memory-write transaction. Its address and data come from two programmable registers. The same transaction goes to every processor-bus port, and the event completes once all of those ports have accepted it. The interrupt therefore enters the chip the same way as any other inbound interrupt write.

When message-signalled interrupts are disabled, hot-plug status is signalled level-style on a legacy message port as a pair of messages: an assert message, and later a deassert message once software has cleared all status bits. A configuration bit picks between the INTx flavour and the hot-plug GPE flavour. Power-management event messages set a write-1-to-clear status bit, which drives an assert/deassert message pair on a separate downstream legacy port.

The hot-plug state machine has five states. HP_IDLE moves to HP_MSI_SEND on "launch write" or to HP_LEG_ASSERT on "launch legacy". HP_MSI_SEND returns to HP_IDLE on "all ports accepted". HP_LEG_ASSERT moves to HP_LEG_HELD on "assert accepted". HP_LEG_HELD moves to HP_LEG_DEASSERT on "status cleared". HP_LEG_DEASSERT returns to HP_IDLE on "deassert accepted".

The power-management state machine follows the same pattern. PM_IDLE moves to PM_ASSERT on "status set". PM_ASSERT moves to PM_HELD on "accepted". PM_HELD moves to PM_DEASSERT on "status cleared". PM_DEASSERT returns to PM_IDLE on "accepted".

Top module: `intr_msg_gen`

## Requirements
- R1: A 1 on any bit of `hp_sb_set` or `hp_ib_set` at a clock edge sets the matching bit of `hp_pending` at that edge. A set wins over a clear of the same bit in the same cycle.
- R2: With `msi_enable` high, a nonzero `hp_pending` seen in HP_IDLE raises every bit of `cpu_wr_valid` on the next cycle. `cpu_wr_addr` and `cpu_wr_data` carry the `msi_addr` and `msi_data` values captured at that launch edge, and later changes to those registers do not affect the write in flight.
- R3: Each `cpu_wr_valid` bit stays high, and the address and data stay stable, until that port's `cpu_wr_ready` is seen. A port that has accepted drops its valid. The write completes only when all ports have accepted, in any order or cycle.
- R4: Completion of a write clears all `hp_pending` bits. Events arriving while the write is in flight merge into the pending status and cause no extra write, so each port sees exactly one handshake.
- R5: With `msi_enable` low, a nonzero `hp_pending` seen in HP_IDLE sends an assert message on the legacy port. `hp_leg_code` bit 1 is `legacy_gpe_sel` (0 = INTx, 1 = hot-plug GPE) and bit 0 is 0 for assert and 1 for deassert. The message is held until `hp_leg_ready`. No processor write is valid at the same time.
- R6: After an assert has been accepted, no further assert is sent. The deassert, with the same flavour bit, is sent only once `hp_pending` is all zero, and never without a prior assert.
- R7: A 1 on a bit of `hp_sts_clr` clears that `hp_pending` bit and leaves the other bits unchanged.
- R8: A pulse on `pme_msg_in` sets `pme_status`. The power-management port then presents an assert message (`pme_leg_deassert` = 0), held until `pme_leg_ready`.
- R9: `pme_status` clears when `pme_sts_clr` is 1 (set wins). Only after it is clear does a deassert message (`pme_leg_deassert` = 1) follow. Further PME messages while an assert is outstanding produce no second assert.
- R10: After reset, all pending and status bits are zero and no output valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_sb_set | input | NUM_SRC | Sideband hot-plug status set, one bit per source |
| hp_ib_set | input | NUM_SRC | In-band hot-plug message status set |
| hp_sts_clr | input | NUM_SRC | Write-1-to-clear of hot-plug status |
| hp_pending | output | NUM_SRC | Hot-plug status bits |
| msi_enable | input | 1 | Message-signalled interrupt enable |
| msi_addr | input | ADDR_W | Programmed interrupt write address |
| msi_data | input | DATA_W | Programmed interrupt write data |
| legacy_gpe_sel | input | 1 | Legacy flavour: 0 INTx, 1 hot-plug GPE |
| cpu_wr_valid | output | NUM_CPU | Write valid per processor-bus port |
| cpu_wr_ready | input | NUM_CPU | Write accepted per processor-bus port |
| cpu_wr_addr | output | ADDR_W | Write address, shared by all ports |
| cpu_wr_data | output | DATA_W | Write data, shared by all ports |
| hp_leg_valid | output | 1 | Hot-plug legacy message valid |
| hp_leg_ready | input | 1 | Hot-plug legacy message accepted |
| hp_leg_code | output | 2 | {flavour, deassert} message code |
| pme_msg_in | input | 1 | Received power-management event message |
| pme_sts_clr | input | 1 | Write-1-to-clear of PME status |
| pme_status | output | 1 | PME status bit |
| pme_leg_valid | output | 1 | Downstream PME message valid |
| pme_leg_ready | input | 1 | Downstream PME message accepted |
| pme_leg_deassert | output | 1 | 0 assert-PME, 1 deassert-PME |

## Verification
The hardest situation to reach is a write in flight in which the two ports accept in different cycles while new events keep arriving, and software changes the address register. The directed sequence holds both readies low, injects events from both set sources, and rewrites `msi_addr`. It then releases one port at a time and checks that each port saw exactly one handshake and that the pending bits merged and cleared. The other hard case is a set and a clear of the same bit in the same cycle, which is driven directly. A long randomized phase then toggles readies, enables, flavours and clears, while a behavioural model is compared with every output on every cycle.

// File: rtl/imsg_pkg.sv
package imsg_pkg;

    typedef enum logic [2:0] {
        HP_IDLE,
        HP_MSI_SEND,
        HP_LEG_ASSERT,
        HP_LEG_HELD,
        HP_LEG_DEASSERT
    } hp_state_e;

    typedef enum logic [1:0] {
        PM_IDLE,
        PM_ASSERT,
        PM_HELD,
        PM_DEASSERT
    } pm_state_e;

    // Legacy message code: bit 1 flavour (1 = hot-plug GPE), bit 0 deassert
    localparam int LEG_CODE_W = 2;

endpackage

// File: rtl/imsg_hp_fsm.sv
module imsg_hp_fsm
    import imsg_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    sb_set,
    input  logic [NUM_SRC-1:0]    ib_set,
    input  logic [NUM_SRC-1:0]    sw_clr,
    output logic [NUM_SRC-1:0]    pending,
    input  logic                  msi_en,
    input  logic [ADDR_W-1:0]     msi_addr,
    input  logic [DATA_W-1:0]     msi_data,
    input  logic                  legacy_gpe,
    output logic [NUM_CPU-1:0]    cpu_valid,
    input  logic [NUM_CPU-1:0]    cpu_ready,
    output logic [ADDR_W-1:0]     cpu_addr,
    output logic [DATA_W-1:0]     cpu_data,
    output logic                  leg_valid,
    input  logic                  leg_ready,
    output logic [LEG_CODE_W-1:0] leg_code
);

    hp_state_e            state_q, state_d;
    logic [NUM_SRC-1:0]   pend_q;
    logic [NUM_CPU-1:0]   taken_q;
    logic [NUM_CPU-1:0]   accepted;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    data_q;
    logic                 gpe_q;
    logic                 write_done;
    logic                 launch_msi;
    logic                 launch_leg;

    assign accepted   = taken_q | cpu_ready;
    assign write_done = (state_q == HP_MSI_SEND) && (&accepted);
    assign launch_msi = (state_q == HP_IDLE) && (|pend_q) && msi_en;
    assign launch_leg = (state_q == HP_IDLE) && (|pend_q) && !msi_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HP_IDLE: begin
                if (launch_msi)      state_d = HP_MSI_SEND;
                else if (launch_leg) state_d = HP_LEG_ASSERT;
            end
            HP_MSI_SEND:     if (write_done)      state_d = HP_IDLE;
            HP_LEG_ASSERT:   if (leg_ready)       state_d = HP_LEG_HELD;
            HP_LEG_HELD:     if (pend_q == '0)    state_d = HP_LEG_DEASSERT;
            HP_LEG_DEASSERT: if (leg_ready)       state_d = HP_IDLE;
            default:                              state_d = HP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HP_IDLE;
        else        state_q <= state_d;
    end

    // status, launch capture and per-port acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            taken_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            gpe_q   <= 1'b0;
        end else begin
            pend_q  <= (pend_q & ~sw_clr & ~{NUM_SRC{write_done}}) | sb_set | ib_set;
            taken_q <= ((state_q == HP_MSI_SEND) && !write_done) ? accepted : '0;
            if (launch_msi) begin
                addr_q <= msi_addr;
                data_q <= msi_data;
            end
            if (launch_leg) gpe_q <= legacy_gpe;
        end
    end

    // outputs
    always_comb begin
        leg_valid = (state_q == HP_LEG_ASSERT) || (state_q == HP_LEG_DEASSERT);
        leg_code  = {gpe_q, state_q == HP_LEG_DEASSERT};
        cpu_addr  = addr_q;
        cpu_data  = data_q;
        pending   = pend_q;
    end

    for (genvar p = 0; p < NUM_CPU; p++) begin : g_port
        assign cpu_valid[p] = (state_q == HP_MSI_SEND) && !taken_q[p];

        AST_CPU_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid[p] && !cpu_ready[p]) |=> cpu_valid[p]); // R3
        AST_CPU_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid[p] && !cpu_ready[p]) |=> ($stable(cpu_addr) && $stable(cpu_data))); // R3
    end

    AST_LEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_valid && !leg_ready) |=> (leg_valid && $stable(leg_code))); // R5
    AST_NO_MIXED_SIGNALLING: assert property (@(posedge clk) disable iff (!rst_n)
        !((|cpu_valid) && leg_valid)); // R5
    AST_DEASSERT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(leg_valid) && leg_code[0]) |-> ($past(pending) == '0)); // R6

endmodule

// File: rtl/imsg_pme_fsm.sv
module imsg_pme_fsm
    import imsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pme_msg,
    input  logic pme_clr,
    output logic status,
    output logic msg_valid,
    input  logic msg_ready,
    output logic msg_deassert
);

    pm_state_e state_q, state_d;
    logic      sts_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_IDLE:     if (sts_q)     state_d = PM_ASSERT;
            PM_ASSERT:   if (msg_ready) state_d = PM_HELD;
            PM_HELD:     if (!sts_q)    state_d = PM_DEASSERT;
            PM_DEASSERT: if (msg_ready) state_d = PM_IDLE;
            default:                    state_d = PM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= 1'b0;
        else        sts_q <= (sts_q & ~pme_clr) | pme_msg;
    end

    always_comb begin
        status       = sts_q;
        msg_valid    = (state_q == PM_ASSERT) || (state_q == PM_DEASSERT);
        msg_deassert = (state_q == PM_DEASSERT);
    end

    AST_PME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_deassert))); // R8
    AST_PME_DEASSERT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msg_valid) && msg_deassert) |-> !$past(status)); // R9

endmodule

// File: rtl/intr_msg_gen.sv
module intr_msg_gen
    import imsg_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    hp_sb_set,
    input  logic [NUM_SRC-1:0]    hp_ib_set,
    input  logic [NUM_SRC-1:0]    hp_sts_clr,
    output logic [NUM_SRC-1:0]    hp_pending,
    input  logic                  msi_enable,
    input  logic [ADDR_W-1:0]     msi_addr,
    input  logic [DATA_W-1:0]     msi_data,
    input  logic                  legacy_gpe_sel,
    output logic [NUM_CPU-1:0]    cpu_wr_valid,
    input  logic [NUM_CPU-1:0]    cpu_wr_ready,
    output logic [ADDR_W-1:0]     cpu_wr_addr,
    output logic [DATA_W-1:0]     cpu_wr_data,
    output logic                  hp_leg_valid,
    input  logic                  hp_leg_ready,
    output logic [LEG_CODE_W-1:0] hp_leg_code,
    input  logic                  pme_msg_in,
    input  logic                  pme_sts_clr,
    output logic                  pme_status,
    output logic                  pme_leg_valid,
    input  logic                  pme_leg_ready,
    output logic                  pme_leg_deassert
);

    imsg_hp_fsm #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_hp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sb_set     (hp_sb_set),
        .ib_set     (hp_ib_set),
        .sw_clr     (hp_sts_clr),
        .pending    (hp_pending),
        .msi_en     (msi_enable),
        .msi_addr   (msi_addr),
        .msi_data   (msi_data),
        .legacy_gpe (legacy_gpe_sel),
        .cpu_valid  (cpu_wr_valid),
        .cpu_ready  (cpu_wr_ready),
        .cpu_addr   (cpu_wr_addr),
        .cpu_data   (cpu_wr_data),
        .leg_valid  (hp_leg_valid),
        .leg_ready  (hp_leg_ready),
        .leg_code   (hp_leg_code)
    );

    imsg_pme_fsm u_pme (
        .clk          (clk),
        .rst_n        (rst_n),
        .pme_msg      (pme_msg_in),
        .pme_clr      (pme_sts_clr),
        .status       (pme_status),
        .msg_valid    (pme_leg_valid),
        .msg_ready    (pme_leg_ready),
        .msg_deassert (pme_leg_deassert)
    );

endmodule

// File: tb/sim_intr_msg_gen.sv
`timescale 1ns/1ps
module sim_intr_msg_gen;
    localparam int NS = 4;
    localparam int NC = 2;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] hp_sb_set = '0, hp_ib_set = '0, hp_sts_clr = '0;
    logic [NS-1:0] hp_pending;
    logic          msi_enable = 1'b0;
    logic [AW-1:0] msi_addr = '0;
    logic [DW-1:0] msi_data = '0;
    logic          legacy_gpe_sel = 1'b0;
    logic [NC-1:0] cpu_wr_valid;
    logic [NC-1:0] cpu_wr_ready = '0;
    logic [AW-1:0] cpu_wr_addr;
    logic [DW-1:0] cpu_wr_data;
    logic          hp_leg_valid;
    logic          hp_leg_ready = 1'b0;
    logic [1:0]    hp_leg_code;
    logic          pme_msg_in = 1'b0, pme_sts_clr = 1'b0;
    logic          pme_status, pme_leg_valid, pme_leg_deassert;
    logic          pme_leg_ready = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    intr_msg_gen #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    bit cmp_on = 1'b0;

    // behavioural reference model
    int            m_hp = 0;    // 0 idle, 1 write, 2 assert, 3 held, 4 deassert
    logic [NC-1:0] m_got = '0;
    logic          m_flav = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    logic [NS-1:0] m_pend = '0;
    int            m_pm = 0;    // 0 idle, 1 assert, 2 held, 3 deassert
    logic          m_pst = 1'b0;

    int n_wr0 = 0, n_wr1 = 0, n_ast = 0, n_dea = 0, n_past = 0, n_pdea = 0;

    task automatic check(string req, string what, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s act=%0h exp=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic          done;
        logic [NS-1:0] npend;
        logic          nst;
        // handshake counters, from pre-edge port values
        if (rst_n) begin
            if (cpu_wr_valid[0] && cpu_wr_ready[0]) n_wr0++;
            if (cpu_wr_valid[1] && cpu_wr_ready[1]) n_wr1++;
            if (hp_leg_valid && hp_leg_ready) begin
                if (hp_leg_code[0]) n_dea++; else n_ast++;
            end
            if (pme_leg_valid && pme_leg_ready) begin
                if (pme_leg_deassert) n_pdea++; else n_past++;
            end
        end
        if (!rst_n) begin
            m_hp = 0; m_got = '0; m_flav = 1'b0; m_addr = '0; m_data = '0;
            m_pend = '0; m_pm = 0; m_pst = 1'b0;
        end else begin
            done  = (m_hp == 1) && ((m_got | cpu_wr_ready) == {NC{1'b1}});
            npend = m_pend & ~hp_sts_clr;
            if (done) npend = '0;
            npend = npend | hp_sb_set | hp_ib_set;
            case (m_hp)
                0: if (m_pend != 0) begin
                       if (msi_enable) begin
                           m_hp = 1; m_addr = msi_addr; m_data = msi_data; m_got = '0;
                       end else begin
                           m_hp = 2; m_flav = legacy_gpe_sel;
                       end
                   end
                1: if (done) begin m_hp = 0; m_got = '0; end
                   else m_got = m_got | cpu_wr_ready;
                2: if (hp_leg_ready) m_hp = 3;
                3: if (m_pend == 0) m_hp = 4;
                4: if (hp_leg_ready) m_hp = 0;
                default: m_hp = 0;
            endcase
            m_pend = npend;
            nst = (m_pst & ~pme_sts_clr) | pme_msg_in;
            case (m_pm)
                0: if (m_pst) m_pm = 1;
                1: if (pme_leg_ready) m_pm = 2;
                2: if (!m_pst) m_pm = 3;
                3: if (pme_leg_ready) m_pm = 0;
                default: m_pm = 0;
            endcase
            m_pst = nst;
        end
    end

    // per-cycle comparison, 5 ns after the edge
    always @(posedge clk) begin
        #5;
        if (cmp_on) begin
            logic [NC-1:0] ev;
            ev = (m_hp == 1) ? ~m_got : '0;
            check("R1", "hp_pending", hp_pending, m_pend);
            check("R3", "cpu_wr_valid", cpu_wr_valid, ev);
            if (m_hp == 1) begin
                check("R2", "cpu_wr_addr", cpu_wr_addr, m_addr);
                check("R2", "cpu_wr_data", cpu_wr_data, m_data);
            end
            check("R5", "hp_leg_valid", hp_leg_valid, (m_hp == 2 || m_hp == 4));
            if (m_hp == 2 || m_hp == 4)
                check("R6", "hp_leg_code", hp_leg_code, {m_flav, m_hp == 4});
            check("R8", "pme_status", pme_status, m_pst);
            check("R8", "pme_leg_valid", pme_leg_valid, (m_pm == 1 || m_pm == 3));
            if (m_pm == 1 || m_pm == 3)
                check("R9", "pme_leg_deassert", pme_leg_deassert, m_pm == 3);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL R10 watchdog expired act=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int b0, b1;
        @(posedge clk);
        cmp_on = 1'b1;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R10 reset state
        check("R10", "reset pending", hp_pending, 0);
        check("R10", "reset valids", {cpu_wr_valid, hp_leg_valid, pme_leg_valid, pme_status}, 0);

        // write path with merge, staggered acceptance and register change in flight
        msi_enable = 1'b1; msi_addr = 32'hFEE0_1000; msi_data = 32'h0000_4041;
        hp_sb_set = 4'b0001; cyc(1); hp_sb_set = '0;
        cyc(2);
        check("R2", "both ports valid", cpu_wr_valid, 2'b11);
        msi_addr = 32'h1234_5678; msi_data = 32'hDEAD_BEEF;
        hp_ib_set = 4'b0100; cyc(1); hp_ib_set = '0;
        hp_sb_set = 4'b1000; cyc(1); hp_sb_set = '0;
        check("R2", "latched address", cpu_wr_addr, 32'hFEE0_1000);
        cpu_wr_ready = 2'b10; cyc(1); cpu_wr_ready = '0;
        cyc(2);
        check("R3", "only port0 still valid", cpu_wr_valid, 2'b01);
        cpu_wr_ready = 2'b01; cyc(1); cpu_wr_ready = '0;
        cyc(3);
        check("R4", "port0 handshakes", n_wr0, 1);
        check("R4", "port1 handshakes", n_wr1, 1);
        check("R4", "pending merged and cleared", hp_pending, 0);

        // legacy INTx pair
        msi_enable = 1'b0; legacy_gpe_sel = 1'b0;
        hp_sb_set = 4'b0011; cyc(1); hp_sb_set = '0;
        cyc(2);
        check("R5", "INTx assert code", {hp_leg_valid, hp_leg_code}, 3'b100);
        hp_ib_set = 4'b0001; cyc(1); hp_ib_set = '0;
        hp_leg_ready = 1'b1; cyc(1); hp_leg_ready = 1'b0;
        cyc(2);
        hp_sts_clr = 4'b0001; cyc(1); hp_sts_clr = '0;
        check("R7", "single bit cleared", hp_pending, 4'b0010);
        cyc(2);
        check("R6", "no deassert while pending", hp_leg_valid, 0);
        check("R6", "single assert", n_ast, 1);
        hp_sts_clr = 4'b0010; hp_leg_ready = 1'b1; cyc(1); hp_sts_clr = '0;
        cyc(4);
        check("R6", "deassert count", n_dea, 1);

        // set wins over clear, GPE flavour
        legacy_gpe_sel = 1'b1; hp_leg_ready = 1'b0;
        hp_sb_set = 4'b1000; hp_sts_clr = 4'b1000; cyc(1);
        hp_sb_set = '0; hp_sts_clr = '0;
        check("R1", "set wins", hp_pending, 4'b1000);
        cyc(2);
        check("R5", "GPE assert code", {hp_leg_valid, hp_leg_code}, 3'b110);
        hp_leg_ready = 1'b1; hp_sts_clr = 4'b1000; cyc(1); hp_sts_clr = '0;
        cyc(4);
        check("R6", "GPE pair counts", {n_ast[7:0], n_dea[7:0]}, 16'h0202);

        // power-management pair
        pme_msg_in = 1'b1; cyc(1); pme_msg_in = 1'b0;
        cyc(1);
        check("R8", "pme status set", pme_status, 1);
        check("R8", "pme assert presented", {pme_leg_valid, pme_leg_deassert}, 2'b10);
        pme_leg_ready = 1'b1; cyc(1);
        pme_msg_in = 1'b1; cyc(1); pme_msg_in = 1'b0;
        cyc(3);
        check("R9", "single pme assert", n_past, 1);
        check("R9", "no deassert before clear", n_pdea, 0);
        pme_sts_clr = 1'b1; cyc(1); pme_sts_clr = 1'b0;
        cyc(3);
        check("R9", "pme status cleared", pme_status, 0);
        check("R9", "pme deassert sent", n_pdea, 1);

        // randomized phase, compared by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            b0 = $urandom_range(0, 99);
            b1 = $urandom_range(0, 99);
            cpu_wr_ready   = NC'($urandom_range(0, 3));
            hp_leg_ready   = ($urandom_range(0, 2) == 0);
            pme_leg_ready  = ($urandom_range(0, 2) == 0);
            hp_sb_set      = (b0 < 8)  ? NS'($urandom_range(1, 15)) : '0;
            hp_ib_set      = (b1 < 5)  ? NS'($urandom_range(1, 15)) : '0;
            hp_sts_clr     = (b0 > 85) ? NS'($urandom_range(1, 15)) : '0;
            pme_msg_in     = (b1 > 95);
            pme_sts_clr    = (b1 < 10);
            if (b0 == 50) msi_enable = ~msi_enable;
            if (b1 == 50) legacy_gpe_sel = ~legacy_gpe_sel;
            msi_addr       = $urandom;
            msi_data       = $urandom;
            cyc(1);
        end
        hp_sb_set = '0; hp_ib_set = '0; hp_sts_clr = '0; pme_msg_in = 1'b0; pme_sts_clr = 1'b0;
        cyc(3);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule